// File: doc/BRIEF.md
# Four-Pin GPIO Port with Standby Isolation

The block controls a small bank of general-purpose pins. Each pin has a direction bit and a data output latch, both reachable over a simple single-cycle register bus. An output pin drives its latch value onto the pad. An input pin is sampled through a two-stage synchronizer. The bus carries a qualifier that marks a read as part of a read-modify-write sequence. Such a read returns the latch contents instead of the pad levels. This keeps bits of input pins intact when software rewrites the whole register.

Two conditions override the pad drivers. The first is a low-power state (stop or watch) combined with an isolation request. In that case every output enable drops, and the input values seen by the read path are clamped to 0, so floating pads cannot leak into logic. The second is a per-pin alternate-select input, driven by an external display controller. It hands a pin over to the LCD supply function and removes its GPIO drive. Pad circuitry, the display controller and the mode sequencer are outside the block.

Top module: `gpio_iso_port`

## Requirements
- R1: Synchronous active-high reset clears the direction and latch registers. After reset, `pad_oe_o`, `pad_out_o` and `reg_rdata_o` are all 0.
- R2: A write at address 1 loads the direction register from `reg_wdata_i[3:0]`, where 1 means output. `pad_oe_o` reflects the new value one clock after the register updates. A read at address 1 returns it.
- R3: An enabled output pin drives the latch bit on `pad_out_o`. A pin whose output enable is 0 drives 0 on `pad_out_o`.
- R4: A write at address 0 always loads the data latch from `reg_wdata_i[3:0]`, including for input pins. An input pin keeps `pad_oe_o` at 0 and shows the stored value only once it becomes an output.
- R5: A normal read at address 0 returns the latch bit for output pins and the synchronized pad level for input pins.
- R6: A read at address 0 with `reg_rmw_i` = 1 returns the latch bit for every pin, whatever the direction.
- R7: While `standby_i` and `iso_en_i` are both 1, every bit of `pad_oe_o` is 0 from the next clock on. Input values seen by a normal read are 0.
- R8: While `standby_i` = 1 and `iso_en_i` = 0, `pad_oe_o` and `pad_out_o` keep the values set by the registers.
- R9: A pin whose `alt_sel_i` bit is 1 has `pad_oe_o` at 0 from the next clock on, whatever its direction bit. Other pins are unaffected.
- R10: Read data appears on `reg_rdata_o` in the clock after the read request. Bits above bit 3 read 0, addresses 2 and 3 read 0, and `reg_rdata_o` is 0 in cycles with no read.
- R11: `iso_en_i` = 1 without `standby_i` has no effect on the output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 2 | Register address (0 data, 1 direction) |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_rmw_i | input | 1 | Marks the read as read-modify-write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, one clock after the strobe |
| pad_in_i | input | 4 | Pad input levels |
| pad_oe_o | output | 4 | Pad output enables |
| pad_out_o | output | 4 | Pad output values |
| alt_sel_i | input | 4 | Per-pin LCD supply function select |
| standby_i | input | 1 | Stop or watch mode active |
| iso_en_i | input | 1 | Pin-state control: isolate pins in standby |

## Verification
A wrong direction or latch bit shows up on `pad_oe_o` or `pad_out_o` within two clocks of the write. It also shows up on the next register read. A mis-steered read path gives away a wrong source only when the latch and the pad differ. For that reason the stimulus always sets the latch and the pad levels to opposing patterns. An isolation or alternate-select fault appears on the enables one clock after the control input changes. An input clamp fault appears on the first normal read taken during isolation.

// File: rtl/gpio_iso_pkg.sv
package gpio_iso_pkg;
  localparam int unsigned ADDR_DATA = 0;
  localparam int unsigned ADDR_DIR  = 1;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_PINVIEW,
    SRC_LATCH,
    SRC_DIR
  } rd_src_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_iso_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic                rmw_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_val_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] latch_o
);
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] latch_q;
  logic [NUM_PINS-1:0] pin_view;
  logic [NUM_PINS-1:0] rd_val;
  logic [DATA_W-1:0]   rdata_q;
  logic                hit_data;
  logic                hit_dir;
  rd_src_e             rd_src;

  assign hit_data = (addr_i == ADDR_W'(ADDR_DATA));
  assign hit_dir  = (addr_i == ADDR_W'(ADDR_DIR));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else if (wr_i) begin
      if (hit_dir)  dir_q   <= wdata_i[NUM_PINS-1:0];
      if (hit_data) latch_q <= wdata_i[NUM_PINS-1:0];
    end
  end

  // per-pin mix: output pins show their latch, input pins their pad
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_view
    assign pin_view[p] = dir_q[p] ? latch_q[p] : pin_val_i[p];
  end

  always_comb begin
    rd_src = SRC_NONE;
    if (rd_i) begin
      if (hit_data)     rd_src = rmw_i ? SRC_LATCH : SRC_PINVIEW;
      else if (hit_dir) rd_src = SRC_DIR;
    end
  end

  always_comb begin
    unique case (rd_src)
      SRC_PINVIEW: rd_val = pin_view;
      SRC_LATCH:   rd_val = latch_q;
      SRC_DIR:     rd_val = dir_q;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= DATA_W'(rd_val);
  end

  assign rdata_o = rdata_q;
  assign dir_o   = dir_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] alt_sel_i,
  input  logic                isolate_i,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] out_o
);
  logic [NUM_PINS-1:0] oe_d;
  logic [NUM_PINS-1:0] oe_q;
  logic [NUM_PINS-1:0] out_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign oe_d[p] = dir_i[p] & ~alt_sel_i[p] & ~isolate_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      out_q <= '0;
    end else begin
      oe_q  <= oe_d;
      out_q <= latch_i & oe_d;
    end
  end

  assign oe_o  = oe_q;
  assign out_o = out_q;
endmodule

// File: rtl/gpio_iso_port.sv
module gpio_iso_port #(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic                reg_rmw_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  input  logic [NUM_PINS-1:0] alt_sel_i,
  input  logic                standby_i,
  input  logic                iso_en_i
);
  logic                isolate;
  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] pin_val;
  logic [NUM_PINS-1:0] dir;
  logic [NUM_PINS-1:0] latch;

  assign isolate = standby_i & iso_en_i;
  // clamp internal input values low while isolated
  assign pin_val = pad_sync & ~{NUM_PINS{isolate}};

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pad_in_i),
    .sync_o  (pad_sync)
  );

  gpio_reg_bank #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .rmw_i     (reg_rmw_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .pin_val_i (pin_val),
    .dir_o     (dir),
    .latch_o   (latch)
  );

  gpio_pad_drive #(.NUM_PINS(NUM_PINS)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .dir_i     (dir),
    .latch_i   (latch),
    .alt_sel_i (alt_sel_i),
    .isolate_i (isolate),
    .oe_o      (pad_oe_o),
    .out_o     (pad_out_o)
  );
endmodule

// File: rtl/gpio_iso_port_chk.sv
module gpio_iso_port_chk #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned DATA_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_rd_i,
  input logic [DATA_W-1:0]   reg_rdata_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] alt_sel_i,
  input logic                standby_i,
  input logic                iso_en_i
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pad_oe_o == '0 && pad_out_o == '0 && reg_rdata_o == '0));

  assert_undriven_low_R3: assert property (@(posedge clk) disable iff (rst)
    (pad_out_o & ~pad_oe_o) == '0);

  assert_iso_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
    (standby_i && iso_en_i) |=> pad_oe_o == '0);

  assert_alt_oe_off_R9: assert property (@(posedge clk) disable iff (rst)
    (|alt_sel_i) |=> (pad_oe_o & $past(alt_sel_i)) == '0);

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> reg_rdata_o == '0);

  if (DATA_W > NUM_PINS) begin : g_upper
    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
      reg_rdata_o[DATA_W-1:NUM_PINS] == '0);
  end
endmodule

bind gpio_iso_port gpio_iso_port_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .pad_oe_o    (pad_oe_o),
  .pad_out_o   (pad_out_o),
  .alt_sel_i   (alt_sel_i),
  .standby_i   (standby_i),
  .iso_en_i    (iso_en_i)
);

// File: tb/gpio_iso_port_tb_top.sv
`timescale 1ns/1ps
module gpio_iso_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr_i = '0;
  logic       reg_wr_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic       reg_rmw_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [3:0] pad_in_i = '0;
  logic [3:0] pad_oe_o;
  logic [3:0] pad_out_o;
  logic [3:0] alt_sel_i = '0;
  logic       standby_i = 1'b0;
  logic       iso_en_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_iso_port dut_i (
    .clk(clk), .rst(rst), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_rd_i(reg_rd_i), .reg_rmw_i(reg_rmw_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .pad_in_i(pad_in_i), .pad_oe_o(pad_oe_o),
    .pad_out_o(pad_out_o), .alt_sel_i(alt_sel_i), .standby_i(standby_i),
    .iso_en_i(iso_en_i)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_rmw_i = rmw; reg_rd_i = 1'b1;
    @(posedge clk); #1;
    d = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 1'b0; reg_rmw_i = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe", {4'h0, pad_oe_o}, 8'h00);
    chk("R1 out", {4'h0, pad_out_o}, 8'h00);
    chk("R1 rdata", reg_rdata_o, 8'h00);
    rd(2'd1, 1'b0, d); chk("R1 dir", d, 8'h00);
    rd(2'd0, 1'b1, d); chk("R1 latch", d, 8'h00);
  endtask

  task automatic t_dir_out();
    logic [7:0] d;
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h05);
    settle();
    chk("R2 oe", {4'h0, pad_oe_o}, 8'h05);
    chk("R3 out", {4'h0, pad_out_o}, 8'h05);
    rd(2'd1, 1'b0, d); chk("R2 dir readback", d, 8'h05);
  endtask

  task automatic t_latch_input();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFA);
    settle();
    chk("R4 oe off", {4'h0, pad_oe_o}, 8'h00);
    chk("R4 out off", {4'h0, pad_out_o}, 8'h00);
    rd(2'd0, 1'b1, d); chk("R4 latch held", d, 8'h0A);
    wr(2'd1, 8'h0F);
    settle();
    chk("R4 shown as output", {4'h0, pad_out_o}, 8'h0A);
  endtask

  task automatic t_mixed_read();
    logic [7:0] d;
    wr(2'd1, 8'h03);
    pad_in_i = 4'b0101;
    settle();
    rd(2'd0, 1'b0, d); chk("R5 mixed read", d, 8'h06);
    rd(2'd0, 1'b1, d); chk("R6 rmw read", d, 8'h0A);
    pad_in_i = 4'b1010;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h05);
    settle();
    rd(2'd0, 1'b0, d); chk("R5 all input", d, 8'h0A);
    rd(2'd0, 1'b1, d); chk("R6 rmw all input", d, 8'h05);
  endtask

  task automatic t_isolation();
    logic [7:0] d;
    pad_in_i = 4'b1111;
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h0C);
    settle();
    chk("R7 pre oe", {4'h0, pad_oe_o}, 8'h0C);
    @(negedge clk); standby_i = 1'b1; iso_en_i = 1'b1;
    @(posedge clk); #1;
    chk("R7 oe forced off", {4'h0, pad_oe_o}, 8'h00);
    chk("R7 out low", {4'h0, pad_out_o}, 8'h00);
    rd(2'd0, 1'b0, d); chk("R7 inputs clamped", d, 8'h08);
    rd(2'd0, 1'b1, d); chk("R6 rmw in isolation", d, 8'h09);
    @(negedge clk); iso_en_i = 1'b0;
    settle();
    chk("R8 oe kept", {4'h0, pad_oe_o}, 8'h0C);
    chk("R8 out kept", {4'h0, pad_out_o}, 8'h08);
    rd(2'd0, 1'b0, d); chk("R8 inputs live", d, 8'h0B);
    @(negedge clk); standby_i = 1'b0; iso_en_i = 1'b1;
    settle();
    chk("R11 iso without standby", {4'h0, pad_oe_o}, 8'h0C);
    @(negedge clk); iso_en_i = 1'b0;
  endtask

  task automatic t_alt();
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h0F);
    @(negedge clk); alt_sel_i = 4'b0100;
    settle();
    chk("R9 alt oe", {4'h0, pad_oe_o}, 8'h0B);
    chk("R9 alt out", {4'h0, pad_out_o}, 8'h0B);
    @(negedge clk); alt_sel_i = 4'b0000;
    settle();
    chk("R9 alt released", {4'h0, pad_oe_o}, 8'h0F);
  endtask

  task automatic t_read_misc();
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, 1'b1, d); chk("R10 upper bits zero", d, 8'h0F);
    rd(2'd2, 1'b0, d); chk("R10 addr2", d, 8'h00);
    rd(2'd3, 1'b1, d); chk("R10 addr3", d, 8'h00);
    @(posedge clk); #1;
    chk("R10 idle rdata", reg_rdata_o, 8'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_dir_out();
    t_latch_input();
    t_mixed_read();
    t_isolation();
    t_alt();
    t_read_misc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule